// File: doc/BRIEF.md
# Overload Recovery Reset Sequencer

This block is the per-channel digital controller that brings a detector channel back into service after a very large implant pulse. A saturation flag from the low-energy amplifier starts it. It then closes bypass switches that hold the high-energy amplifier on the detector input while that amplifier integrates the charge. After that it opens the switches and resets the analogue stages in order: first a reset strobe to the low-energy amplifier, then a separate reset strobe to the shaper, then a quiet settling interval. The low-energy comparator enable stays low through all of this and returns only after the settling interval, so charge injected by the resets cannot cause a false trigger.

Each interval is a programmable count of clock cycles. The four counts are captured when a sequence starts, and changes on the configuration inputs during a sequence have no effect on it. At a 125 MHz clock with 8-bit counts, every interval can be set between 8 ns and about 2 µs, so a complete recovery fits within a few microseconds.

Top module: `ovr_recovery_seq`

## Requirements
- R1: While the active-low reset is low, and after it is released, the block is idle: bypassEn, ampRst, shaperRst and busy are 0, and compEn is 1. The reset acts asynchronously, also in the middle of a sequence.
- R2: When satFlag is 1 at a rising clock edge while the block is idle, bypassEn is 1 in the cycle after that edge and stays at 1 for exactly cfgIntegCycles cycles.
- R3: After bypassEn falls there is exactly one cycle in which bypassEn, ampRst and shaperRst are all 0 and busy is 1, before any reset strobe starts.
- R4: ampRst is then 1 for exactly cfgAmpRstCycles cycles, followed directly by shaperRst at 1 for exactly cfgShpRstCycles cycles. The two strobes are never 1 in the same cycle.
- R5: After shaperRst falls, all strobes stay 0 for exactly cfgSettleCycles cycles with compEn at 0. compEn returns to 1 in the cycle after that.
- R6: busy is 1 from the first bypass cycle up to and including the last settle cycle, and compEn equals the inverse of busy in every cycle.
- R7: The four interval counts are sampled at the edge that starts a sequence. Changes on the configuration inputs during a sequence do not alter its timing.
- R8: satFlag is ignored while busy is 1, including in the last settle cycle. A new sequence can start at the first edge at which the block is idle.
- R9: A configured count of 0 behaves the same as a count of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rstN | input | 1 | Asynchronous active-low reset |
| satFlag | input | 1 | Low-energy amplifier saturation indication |
| cfgIntegCycles | input | CW (8) | High-energy integration interval, in cycles |
| cfgAmpRstCycles | input | CW (8) | Amplifier reset strobe width, in cycles |
| cfgShpRstCycles | input | CW (8) | Shaper reset strobe width, in cycles |
| cfgSettleCycles | input | CW (8) | Settling interval before the comparator is re-enabled, in cycles |
| bypassEn | output | 1 | Closes the switches that connect the high-energy amplifier |
| ampRst | output | 1 | Low-energy amplifier reset strobe |
| shaperRst | output | 1 | Shaper reset strobe |
| compEn | output | 1 | Low-energy comparator enable |
| busy | output | 1 | Recovery sequence in progress |

## Verification
The hardest cases to reach from the ports are the edges of each interval: a saturation pulse that arrives in the very last settle cycle, a new sequence that starts in the first idle cycle, and zero-valued counts. The stimulus drives the saturation flag again at chosen offsets inside a running sequence. It also changes the configuration inputs on every cycle while a sequence runs, and it starts sequences back to back. The expected per-cycle output pattern for each of these cases is built from the captured counts alone.

// File: rtl/ovr_recovery_pkg.sv
package ovr_recovery_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SW_ON,
    ST_SW_OFF,
    ST_AMP_RST,
    ST_SHP_RST,
    ST_SETTLE
  } seqState_t;

  // strobes from control to the interval datapath
  typedef struct packed {
    logic capture;     // latch configuration and load integration count
    logic loadAmp;     // load amplifier reset width
    logic loadShp;     // load shaper reset width
    logic loadSettle;  // load settle time
  } cntCtrl_t;

endpackage

// File: rtl/ovr_interval_dp.sv
module ovr_interval_dp
  import ovr_recovery_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  cntCtrl_t      ctrl,
  input  logic [CW-1:0] cfgInteg,
  input  logic [CW-1:0] cfgAmp,
  input  logic [CW-1:0] cfgShp,
  input  logic [CW-1:0] cfgSettle,
  output logic          cntDone
);

  localparam logic [CW-1:0] ZERO = '0;
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] ampReg, shpReg, settleReg;
  logic [CW-1:0] cnt;

  // a count of N gives N cycles in the state; zero is treated as one
  function automatic logic [CW-1:0] lastIdx(input logic [CW-1:0] n);
    return (n == ZERO) ? ZERO : n - ONE;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ampReg    <= '0;
      shpReg    <= '0;
      settleReg <= '0;
      cnt       <= '0;
    end else if (ctrl.capture) begin
      ampReg    <= cfgAmp;
      shpReg    <= cfgShp;
      settleReg <= cfgSettle;
      cnt       <= lastIdx(cfgInteg);
    end else if (ctrl.loadAmp) begin
      cnt <= lastIdx(ampReg);
    end else if (ctrl.loadShp) begin
      cnt <= lastIdx(shpReg);
    end else if (ctrl.loadSettle) begin
      cnt <= lastIdx(settleReg);
    end else if (cnt != ZERO) begin
      cnt <= cnt - ONE;
    end
  end

  assign cntDone = (cnt == ZERO);

  // R7: captured widths only change at the start of a sequence
  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.capture |=> ($stable(ampReg) && $stable(shpReg) && $stable(settleReg)));

  // R2: a running interval counts down by one per cycle
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl == '0 && !cntDone) |=> (cnt == $past(cnt) - ONE));

endmodule

// File: rtl/ovr_seq_ctrl.sv
module ovr_seq_ctrl
  import ovr_recovery_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     satFlag,
  input  logic     cntDone,
  output cntCtrl_t ctrl,
  output logic     bypassEn,
  output logic     ampRst,
  output logic     shaperRst,
  output logic     compEn,
  output logic     busy
);

  seqState_t state, stateNxt;

  always_comb begin
    stateNxt = state;
    ctrl     = '0;
    unique case (state)
      ST_IDLE: if (satFlag) begin
        stateNxt     = ST_SW_ON;
        ctrl.capture = 1'b1;
      end
      ST_SW_ON:  if (cntDone) stateNxt = ST_SW_OFF;
      ST_SW_OFF: begin
        stateNxt     = ST_AMP_RST;
        ctrl.loadAmp = 1'b1;
      end
      ST_AMP_RST: if (cntDone) begin
        stateNxt     = ST_SHP_RST;
        ctrl.loadShp = 1'b1;
      end
      ST_SHP_RST: if (cntDone) begin
        stateNxt        = ST_SETTLE;
        ctrl.loadSettle = 1'b1;
      end
      ST_SETTLE: if (cntDone) stateNxt = ST_IDLE;
      default:   stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  assign bypassEn  = (state == ST_SW_ON);
  assign ampRst    = (state == ST_AMP_RST);
  assign shaperRst = (state == ST_SHP_RST);
  assign busy      = (state != ST_IDLE);
  assign compEn    = (state == ST_IDLE);

  // R2: saturation seen in idle closes the bypass switches next cycle
  p_sat_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && satFlag) |=> bypassEn);

  // R3: switches open with a quiet gap before any reset strobe
  p_gap_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(bypassEn) |-> (!ampRst && !shaperRst && busy));

  // R4: shaper reset only follows amplifier reset
  p_amp_then_shp_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(shaperRst) |-> $past(ampRst));

  // R5: comparator returns only after a quiet settle cycle
  p_comp_after_settle_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(compEn) |-> $past(busy && !ampRst && !shaperRst && !bypassEn));

  // R6: busy only starts from a saturation indication
  p_busy_start_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(satFlag));

  // R8: saturation while busy never reopens the bypass phase
  p_ignore_sat_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && satFlag) |=> !$rose(bypassEn));

endmodule

// File: rtl/ovr_recovery_seq.sv
module ovr_recovery_seq
  import ovr_recovery_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          satFlag,
  input  logic [CW-1:0] cfgIntegCycles,
  input  logic [CW-1:0] cfgAmpRstCycles,
  input  logic [CW-1:0] cfgShpRstCycles,
  input  logic [CW-1:0] cfgSettleCycles,
  output logic          bypassEn,
  output logic          ampRst,
  output logic          shaperRst,
  output logic          compEn,
  output logic          busy
);

  cntCtrl_t ctrl;
  logic     cntDone;

  ovr_seq_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .satFlag   (satFlag),
    .cntDone   (cntDone),
    .ctrl      (ctrl),
    .bypassEn  (bypassEn),
    .ampRst    (ampRst),
    .shaperRst (shaperRst),
    .compEn    (compEn),
    .busy      (busy)
  );

  ovr_interval_dp #(.CW(CW)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .cfgInteg  (cfgIntegCycles),
    .cfgAmp    (cfgAmpRstCycles),
    .cfgShp    (cfgShpRstCycles),
    .cfgSettle (cfgSettleCycles),
    .cntDone   (cntDone)
  );

  // R4: the two reset strobes never overlap at the ports
  p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(ampRst && shaperRst));

endmodule

// File: tb/ovr_recovery_seq_tb.sv
`timescale 1ns/1ps
module ovr_recovery_seq_tb_top;

  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          satFlag = 1'b0;
  logic [CW-1:0] cfgI = '0, cfgA = '0, cfgS = '0, cfgT = '0;
  logic          bypassEn, ampRst, shaperRst, compEn, busy;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [4:0] v;   // {bypassEn, ampRst, shaperRst, compEn, busy}
    string      tag;
  } expItem_t;

  expItem_t sbq[$];

  localparam logic [4:0] V_IDLE = 5'b00010;
  localparam logic [4:0] V_BYP  = 5'b10001;
  localparam logic [4:0] V_GAP  = 5'b00001;
  localparam logic [4:0] V_AMP  = 5'b01001;
  localparam logic [4:0] V_SHP  = 5'b00101;

  always #4 clk = ~clk;  // 125 MHz

  ovr_recovery_seq #(.CW(CW)) dut_i (
    .clk(clk), .rstN(rstN), .satFlag(satFlag),
    .cfgIntegCycles(cfgI), .cfgAmpRstCycles(cfgA),
    .cfgShpRstCycles(cfgS), .cfgSettleCycles(cfgT),
    .bypassEn(bypassEn), .ampRst(ampRst), .shaperRst(shaperRst),
    .compEn(compEn), .busy(busy)
  );

  function automatic logic [4:0] outs();
    return {bypassEn, ampRst, shaperRst, compEn, busy};
  endfunction

  task automatic checkNow(input logic [4:0] exp, input string tag);
    checks++;
    if (outs() !== exp) begin
      fails++;
      $display("FAIL %s: outputs=%b expected=%b at %0t", tag, outs(), exp, $time);
    end
  endtask

  function automatic int eff(input int n);
    return (n == 0) ? 1 : n;
  endfunction

  // driver: starts a sequence, optional saturation re-pulse at offset glitchK,
  // optional configuration scrambling, and pushes the expected per-cycle outputs
  task automatic runSeq(input int i, input int a, input int s, input int t,
                        input int glitchK, input bit scramble, input int tail,
                        input string tag);
    int ei = eff(i), ea = eff(a), es = eff(s), et = eff(t);
    int total = ei + 1 + ea + es + et;
    expItem_t it;
    for (int k = 0; k < total + tail; k++) begin
      @(negedge clk);
      if (k == 0) begin
        cfgI = CW'(i); cfgA = CW'(a); cfgS = CW'(s); cfgT = CW'(t);
        satFlag = 1'b1;
      end else begin
        satFlag = (k == glitchK);
        if (scramble) begin
          cfgI = CW'(k * 7 + 3); cfgA = CW'(k * 5 + 1);
          cfgS = CW'(k * 3 + 2); cfgT = CW'(k * 11);
        end
      end
      it.tag = tag;
      if (k < ei)                       it.v = V_BYP;
      else if (k < ei + 1)              it.v = V_GAP;
      else if (k < ei + 1 + ea)         it.v = V_AMP;
      else if (k < ei + 1 + ea + es)    it.v = V_SHP;
      else if (k < total)               it.v = V_GAP;  // settle: only busy high
      else                              it.v = V_IDLE;
      sbq.push_back(it);
    end
    @(negedge clk);
    satFlag = 1'b0;
  endtask

  // monitor: compares after each rising edge, away from the edge
  initial begin
    expItem_t it;
    forever begin
      @(posedge clk);
      #2;
      if (rstN && sbq.size() > 0) begin
        it = sbq.pop_front();
        checkNow(it.v, it.tag);
      end
    end
  end

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1: idle during reset
    repeat (3) @(negedge clk);
    checkNow(V_IDLE, "R1 during reset");
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    checkNow(V_IDLE, "R1 after reset release");

    // R2 R3 R4 R5 R6: plain sequence
    runSeq(4, 3, 2, 5, -1, 1'b0, 3, "R2/R3/R4/R5/R6 basic");
    // R2 R4 R5: different widths
    runSeq(1, 6, 4, 2, -1, 1'b0, 2, "R4/R5 alt widths");
    // R8: saturation again early in the sequence
    runSeq(3, 2, 2, 3, 1, 1'b0, 2, "R8 early re-pulse");
    // R8: saturation in the last settle cycle
    runSeq(2, 2, 3, 4, 12, 1'b0, 3, "R8 last settle cycle");
    // R7: configuration changes every cycle during the run
    runSeq(5, 4, 3, 6, -1, 1'b1, 2, "R7 config scrambled");
    // R9: zero counts act as one
    runSeq(0, 0, 0, 0, -1, 1'b0, 2, "R9 zero counts");
    // R8/R6: back-to-back starts at first idle edge
    runSeq(2, 1, 1, 1, -1, 1'b0, 0, "R6 back-to-back first");
    runSeq(3, 2, 1, 2, -1, 1'b0, 2, "R8 back-to-back second");

    // R1: asynchronous reset mid-sequence
    @(negedge clk);
    cfgI = 8'd20; cfgA = 8'd5; cfgS = 8'd5; cfgT = 8'd5;
    satFlag = 1'b1;
    @(negedge clk);
    satFlag = 1'b0;
    checkNow(V_BYP, "R2 before mid-run reset");
    repeat (3) @(negedge clk);
    rstN = 1'b0;
    #1;
    checkNow(V_IDLE, "R1 async reset mid-sequence");
    @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    checkNow(V_IDLE, "R1 idle after mid-run reset");

    // R2: a fresh sequence still works after that reset
    runSeq(2, 2, 2, 2, -1, 1'b0, 2, "R2 after reset");

    repeat (3) @(negedge clk);
    if (sbq.size() != 0) begin
      fails++;
      $display("FAIL R6: scoreboard left=%0d expected=0", sbq.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule